// File: doc/BRIEF.md
# Byte-Port Digital I/O Controller

A 32-channel general-purpose digital I/O block organised as four 8-bit ports and attached to a byte-wide register bus. Each port has an output latch, and software writes it through a data address. Reading that same address returns the level on the port's pins after synchronisation. The pin side has three 32-bit vectors: output value, output enable and input sample. Bit 8p+k belongs to port p, line k.

Whether a port drives is decided per port, never per line. Three configuration bytes take part. The direction/enable byte carries a direction bit and a buffer-disable bit for every port. Two pair-control bytes, one for ports 0/1 and one for ports 2/3, each carry an "is input" mark per port plus a set flag. A port drives only when all three sources agree. Software normally writes the 0/1 control byte, then the 2/3 control byte, then the direction/enable byte. After reset every register is zero, so every port is an input.

Top module: `byteport_dio`

## Requirements
- R1: While reset is asserted and after it is released, `pin_oe` and `pin_out` are all zero, and the configuration bytes at 0x82, 0x83 and 0xC3 read back as 0x00.
- R2: A bus write to data address 0x80, 0x81, 0xC0 or 0xC1 loads port 0, 1, 2 or 3 respectively. The value appears on `pin_out[8p+7:8p]` in the cycle after the write edge, and the other ports' bytes are unchanged.
- R3: A data write reaches the output latch even while the port is an input, with `pin_oe` staying low. When the port later becomes an output, the latched value is what it drives.
- R4: The 8 enable bits of a port are always all equal (0x00 or 0xFF). They are high only when the port's direction bit is 1, its buffer-disable bit is 0 and its input mark is 0.
- R5: Direction/enable byte at 0x82. Bits 2, 3, 6 and 7 set ports 0, 1, 2 and 3 as outputs. Bits 0, 1, 4 and 5 disable the buffers of ports 0, 1, 2 and 3.
- R6: Pair-control bytes at 0x83 (ports 0/1) and 0xC3 (ports 2/3). In each byte, bit 4 marks the lower port of the pair as input and bit 1 marks the upper port. Bit 7 is the set flag: it is stored and read back and does not by itself change any enable.
- R7: After the write sequence 0x83, then 0xC3, then 0x82, `pin_oe` matches the combination of all three bytes in the cycle after the last write. `pin_oe` changes only in the cycle after a write to one of these three addresses.
- R8: A read of a data address returns that port's pin level. A level held on `pin_in` for at least `SYNC_STAGES` clock edges before the read edge is returned.
- R9: `bus_rdata` is registered and valid in the cycle after the read strobe. It holds its value until the next read.
- R10: Reads of 0x82, 0x83 and 0xC3 return the last value written. Other addresses read 0x00, and writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_out | output | 32 | Output value per line |
| pin_oe | output | 32 | Output enable per line |
| pin_in | input | 32 | Pin level sample |

## Verification
Writes take effect at the write clock edge, and `pin_out` and `pin_oe` are due in the cycle right after, so the bench drives on the falling edge and checks on the next falling edge. Read data is registered and is therefore due one cycle after the strobe. A pin change needs two synchroniser edges before a read edge can capture it, so the bench holds `pin_in` for two cycles before it issues the read. The vector table runs the full three-write configuration sequence, and the enables are checked only after the last write.

// File: rtl/byteport_dio_pkg.sv
package byteport_dio_pkg;
   localparam int ADDR_W  = 8;
   localparam int BYTE_W  = 8;
   localparam int N_PORTS = 4;
   localparam int PINS_W  = N_PORTS * BYTE_W;

   localparam logic [ADDR_W-1:0] A_DIRENA = 8'h82;
   localparam logic [ADDR_W-1:0] A_CTL01  = 8'h83;
   localparam logic [ADDR_W-1:0] A_CTL23  = 8'hC3;

   // pair 0 holds ports 0/1, pair 1 holds ports 2/3
   function automatic logic [ADDR_W-1:0] data_addr(input int p);
      return ((p / 2) == 0 ? 8'h80 : 8'hC0) + ADDR_W'(p % 2);
   endfunction

   function automatic int dir_bit(input int p);
      return (p / 2) * 4 + 2 + (p % 2);
   endfunction

   function automatic int dis_bit(input int p);
      return (p / 2) * 4 + (p % 2);
   endfunction

   function automatic int in_bit(input int p);
      return (p % 2) == 0 ? 4 : 1;
   endfunction
endpackage

// File: rtl/bpd_sync.sv
module bpd_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] sr [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("bpd_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr[s] <= '0;
            else if (s == 0) sr[s] <= d;
            else             sr[s] <= sr[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/bpd_port.sv
module bpd_port #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [BW-1:0] ld_val,
   input  logic          dir_out,
   input  logic          buf_off,
   input  logic          mark_in,
   output logic [BW-1:0] q_out,
   output logic [BW-1:0] q_oe
);
   logic [BW-1:0] latch_q;
   logic          drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  latch_q <= '0;
      else if (ld) latch_q <= ld_val;
   end

   assign drive = dir_out & ~buf_off & ~mark_in;
   assign q_out = latch_q;
   assign q_oe  = {BW{drive}};
endmodule

// File: rtl/byteport_dio.sv
module byteport_dio
   import byteport_dio_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [PINS_W-1:0] pin_out,
   output logic [PINS_W-1:0] pin_oe,
   input  logic [PINS_W-1:0] pin_in
);
   logic [BYTE_W-1:0] direna_q, ctl01_q, ctl23_q, rdata_q, rd_mux;
   logic [PINS_W-1:0] pin_sync;
   logic [N_PORTS-1:0] port_hit;

   generate
      if (SYNC_STAGES < 2) begin : g_chk
         $error("SYNC_STAGES must be two or more");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         direna_q <= '0;
         ctl01_q  <= '0;
         ctl23_q  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_DIRENA) direna_q <= bus_wdata;
         if (bus_addr == A_CTL01)  ctl01_q  <= bus_wdata;
         if (bus_addr == A_CTL23)  ctl23_q  <= bus_wdata;
      end
   end

   bpd_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port
         localparam logic [ADDR_W-1:0] MY_ADDR = data_addr(p);
         logic mark;
         assign port_hit[p] = (bus_addr == MY_ADDR);
         assign mark = (p / 2 == 0) ? ctl01_q[in_bit(p)] : ctl23_q[in_bit(p)];
         bpd_port #(.BW(BYTE_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (bus_wr && port_hit[p]),
            .ld_val (bus_wdata),
            .dir_out(direna_q[dir_bit(p)]),
            .buf_off(direna_q[dis_bit(p)]),
            .mark_in(mark),
            .q_out  (pin_out[p*BYTE_W +: BYTE_W]),
            .q_oe   (pin_oe[p*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < N_PORTS; p++)
         if (port_hit[p]) rd_mux = pin_sync[p*BYTE_W +: BYTE_W];
      if (bus_addr == A_DIRENA) rd_mux = direna_q;
      if (bus_addr == A_CTL01)  rd_mux = ctl01_q;
      if (bus_addr == A_CTL23)  rd_mux = ctl23_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker
   import byteport_dio_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic [PINS_W-1:0] pin_out,
   input logic [PINS_W-1:0] pin_oe
);
   // R1: right after reset release nothing drives
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

   // R7: enables move only after a configuration write
   a_r7_oe_needs_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> ($past(bus_wr) &&
         ($past(bus_addr) == A_DIRENA || $past(bus_addr) == A_CTL01 ||
          $past(bus_addr) == A_CTL23)));

   // R9: read data holds between reads
   a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_rdata) |-> $past(bus_rd));

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_p
         localparam logic [ADDR_W-1:0] PA = data_addr(p);
         // R4: enables of one port move together
         a_r4_port_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(pin_oe[p*BYTE_W +: BYTE_W]) == 0 ||
             $countones(pin_oe[p*BYTE_W +: BYTE_W]) == BYTE_W));
         // R2: a data write lands on that port's output byte
         a_r2_data_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == PA) |=> (pin_out[p*BYTE_W +: BYTE_W] == $past(bus_wdata)));
         // R10: the byte only changes when its own address is written
         a_r10_out_needs_own_write: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pin_out[p*BYTE_W +: BYTE_W]) |-> ($past(bus_wr) && $past(bus_addr) == PA));
      end
   endgenerate
endmodule

bind byteport_dio bpd_checker u_chk (.*);

// File: tb/byteport_dio_test.sv
module byteport_dio_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [31:0] pin_out, pin_oe;
   logic [31:0] pin_in = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   byteport_dio uut (.*);

   // {direna, ctl01, ctl23, expected driving ports (bit p = port p)}
   localparam logic [27:0] VEC [6] = '{
      {8'h00, 8'h00, 8'h00, 4'b0000},
      {8'hCC, 8'h00, 8'h00, 4'b1111},
      {8'hCC, 8'h10, 8'h02, 4'b0110},
      {8'hFF, 8'h00, 8'h00, 4'b0000},
      {8'h4D, 8'h80, 8'h80, 4'b0110},
      {8'hCC, 8'h12, 8'h82, 4'b0100}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] expand(input logic [3:0] m);
      logic [31:0] r = '0;
      for (int p = 0; p < 4; p++) if (m[p]) r[p*8 +: 8] = 8'hFF;
      return r;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pin_oe, 32'h0);
      chk("R1 out in reset", pin_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h82, r); chk("R1 direna reset", {24'h0, r}, 32'h0);
      rd(8'h83, r); chk("R1 ctl01 reset", {24'h0, r}, 32'h0);
      rd(8'hC3, r); chk("R1 ctl23 reset", {24'h0, r}, 32'h0);

      // R4 R5 R6 R7: configuration sequence table
      for (int i = 0; i < 6; i++) begin
         wr(8'h83, VEC[i][19:12]);
         wr(8'hC3, VEC[i][11:4]);
         wr(8'h82, VEC[i][27:20]);
         chk("R7 R4 R5 R6 oe after sequence", pin_oe, expand(VEC[i][3:0]));
      end

      // R3: latch while input, drive later
      wr(8'h82, 8'h00); wr(8'h83, 8'h00); wr(8'hC3, 8'h00);
      wr(8'h80, 8'hA5);
      chk("R3 latch while input", pin_out[7:0], 32'hA5);
      chk("R3 no drive while input", pin_oe, 32'h0);
      wr(8'h82, 8'h04);
      chk("R3 drive after dir", pin_oe, 32'h0000_00FF);
      chk("R3 latched value kept", pin_out[7:0], 32'hA5);

      // R2: each data address
      wr(8'h81, 8'h3C); wr(8'hC0, 8'h5A); wr(8'hC1, 8'hC3);
      chk("R2 data map", pin_out, 32'hC35A_3CA5);
      wr(8'hC0, 8'h11);
      chk("R2 single byte", pin_out, 32'hC311_3CA5);

      // R8: pin readback through synchroniser
      @(negedge clk); pin_in = 32'h1122_3344;
      repeat (2) @(negedge clk);
      rd(8'h80, r); chk("R8 port0 pins", {24'h0, r}, 32'h44);
      rd(8'h81, r); chk("R8 port1 pins", {24'h0, r}, 32'h33);
      rd(8'hC0, r); chk("R8 port2 pins", {24'h0, r}, 32'h22);
      rd(8'hC1, r); chk("R8 port3 pins", {24'h0, r}, 32'h11);

      // R9: read data holds
      repeat (3) @(negedge clk);
      chk("R9 rdata holds", {24'h0, bus_rdata}, 32'h11);

      // R10: readback and unmapped addresses
      wr(8'h83, 8'h92);
      rd(8'h83, r); chk("R10 ctl01 readback", {24'h0, r}, 32'h92);
      chk("R6 port0 marked input", pin_oe, 32'h0);
      wr(8'h83, 8'h00);
      wr(8'h84, 8'hFF); wr(8'h40, 8'hFF); wr(8'hC2, 8'hFF);
      chk("R10 unmapped no out change", pin_out, 32'hC311_3CA5);
      chk("R10 unmapped no oe change", pin_oe, 32'h0000_00FF);
      rd(8'h84, r); chk("R10 unmapped reads zero", {24'h0, r}, 32'h0);
      rd(8'h82, r); chk("R10 direna kept", {24'h0, r}, 32'h04);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset clears oe", pin_oe, 32'h0);
      chk("R1 reset clears out", pin_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule